// File: doc/BRIEF.md
# UART Receiver with Overrun Discard

This block is an asynchronous serial receiver. It watches one RX line, samples it on a baud tick that runs at sixteen times the bit rate, and builds frames. Each frame has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A finished frame is copied into a holding data register, and a single-cycle completion pulse is raised.

A small set of flags reports three errors: a parity mismatch, a stop bit sampled low, and a frame that arrives while the previous byte is still unread. In the last case the new byte is thrown away and the held byte is kept. A parity or stop-bit error does not abort the frame, so the completion pulse still fires. Software-side logic reads the byte with a one-cycle read strobe, which frees the register and clears every flag.

The receiver runs only while both a power control and a receive-enable control are high. After it is enabled, it must see the line high (idle) before a falling edge can begin a frame.

Top module: `uart_rx_core`

## Requirements
- R1: The receiver leaves its idle state only while both `pwr_en` and `rx_en` are 1. Clearing either one, even in the middle of a frame, returns it to idle, and that frame produces no `rx_done`.
- R2: After it is enabled, the receiver accepts a falling edge as a possible start only after it has seen the line high. A line that is already low at enable never starts a frame.
- R3: A falling edge is confirmed as a start bit only if the line is still low at tick 8 of the start bit. Otherwise the receiver returns to waiting for a high line, and no frame is reported.
- R4: Each bit lasts 16 baud ticks and is sampled at its middle. The eight data bits arrive least significant bit first, and they appear on `rx_data` with D0 at bit 0.
- R5: At the stop-bit sample, `rx_done` is high for exactly one clock, in the same clock in which `rx_data` and `full` take the new frame (when no overrun occurs).
- R6: If a frame completes while `full` is 1 and no read is strobed, `err_overrun` is set, the new byte is discarded and `rx_data` keeps the old byte. Every later frame does the same until a read happens.
- R7: `par_mode` selects the parity: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. With parity on, a parity bit follows D7, and a mismatch sets `err_parity` while the frame still completes with `rx_done`.
- R8: A stop bit sampled low sets `err_frame`, and the frame still completes with `rx_done`.
- R9: Only one stop bit is checked. Right after the stop sample the receiver looks for the next start, so frames sent back to back with one stop bit are all received.
- R10: A `rd_strobe` pulse clears `full`, `err_parity`, `err_frame` and `err_overrun`. A frame that completes in the same clock wins and loads normally.
- R11: After reset, `rx_data` is 0, and `full`, all error flags and `rx_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power control; receiver runs only while high |
| rx_en | input | 1 | Receive enable; receiver runs only while high |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| par_mode | input | 2 | Parity selection (00 none, 01 even, 10 odd, 11 none) |
| rd_strobe | input | 1 | One-clock read of the data register |
| rx_data | output | 8 | Held received byte |
| rx_done | output | 1 | One-clock frame completion pulse |
| full | output | 1 | Data register holds an unread byte |
| err_parity | output | 1 | Parity mismatch flag |
| err_frame | output | 1 | Low stop bit flag |
| err_overrun | output | 1 | Frame arrived while register full; byte dropped |

## Verification
The bench holds the line low across enable. A receiver that skipped the idle-high step would start on that level and report a garbage frame or an extra completion. It also sends a low glitch shorter than half a bit, which a receiver that did not re-check the start bit would frame as data. It sends several frames without reading. A design that overwrote on overrun would show the newer byte, and one that cleared overrun on its own would stop flagging the later frames. Back-to-back frames with a single stop bit show whether the receiver waits for a phantom second stop bit. A frame cut off by dropping power shows whether a stale completion leaks out.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int MID       = OVS / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_en,
  input  logic                 rx_en,
  input  logic                 baud_tick,
  input  logic                 rx_in,
  input  logic [1:0]           par_mode,
  input  logic                 rd_strobe,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_done,
  output logic                 full,
  output logic                 err_parity,
  output logic                 err_frame,
  output logic                 err_overrun
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_BITS);
  localparam logic [IW-1:0] LAST   = IW'(DATA_BITS - 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID = CW'(MID - 1);

  typedef enum logic [2:0] {S_OFF, S_ARM, S_WAIT, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                  st;
  logic [1:0]           sync;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_acc, par_bad;

  wire rx_s    = sync[1];
  wire active  = pwr_en & rx_en;
  wire samp    = baud_tick && (cnt == CNT_END);
  wire use_par = (par_mode == 2'b01) || (par_mode == 2'b10);
  wire odd     = (par_mode == 2'b10);
  wire finish  = active && (st == S_STOP) && samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      st <= S_OFF;
      cnt <= '0;
      idx <= '0;
      shreg <= '0;
      par_acc <= 1'b0;
      par_bad <= 1'b0;
      rx_data <= '0;
      rx_done <= 1'b0;
      full <= 1'b0;
      err_parity <= 1'b0;
      err_frame <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      sync <= {sync[0], rx_in};
      rx_done <= 1'b0;
      if (rd_strobe) begin
        full <= 1'b0;
        err_parity <= 1'b0;
        err_frame <= 1'b0;
        err_overrun <= 1'b0;
      end
      if ((st == S_DATA || st == S_PAR || st == S_STOP) && baud_tick)
        cnt <= samp ? '0 : cnt + 1'b1;
      if (!active) st <= S_OFF;
      else begin
        case (st)
          S_OFF:  st <= S_ARM;
          S_ARM:  if (rx_s) st <= S_WAIT;
          S_WAIT: if (!rx_s) begin st <= S_START; cnt <= '0; end
          S_START:
            if (baud_tick) begin
              if (cnt == CNT_MID) begin
                cnt <= '0;
                if (!rx_s) begin
                  st <= S_DATA; idx <= '0; par_acc <= 1'b0; par_bad <= 1'b0;
                end else st <= S_ARM;
              end else cnt <= cnt + 1'b1;
            end
          S_DATA:
            if (samp) begin
              shreg <= {rx_s, shreg[DATA_BITS-1:1]};
              par_acc <= par_acc ^ rx_s;
              idx <= idx + 1'b1;
              if (idx == LAST) st <= use_par ? S_PAR : S_STOP;
            end
          S_PAR:
            if (samp) begin
              par_bad <= par_acc ^ rx_s ^ odd;
              st <= S_STOP;
            end
          S_STOP:
            if (samp) begin
              rx_done <= 1'b1;
              st <= S_ARM;
              if (full && !rd_strobe) begin
                err_overrun <= 1'b1;
                err_parity <= err_parity | par_bad;
                err_frame <= err_frame | !rx_s;
              end else begin
                rx_data <= shreg;
                full <= 1'b1;
                err_parity <= par_bad;
                err_frame <= !rx_s;
              end
            end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R5
  AST_OFF_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rx_done); // R1
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_strobe) |=> $stable(rx_data)); // R6
  AST_FLAGS_NEED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity || err_frame || err_overrun) |-> full); // R10
  AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !finish) |=> (!full && !err_overrun)); // R10
  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> full); // R5
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  logic clk = 0, rst_n = 0, pwr_en = 0, rx_en = 0, baud_tick = 0, rx_in = 1;
  logic [1:0] par_mode = 2'b00;
  logic rd_auto = 0, rd_man = 0, auto_rd = 1;
  logic [7:0] rx_data;
  logic rx_done, full, err_parity, err_frame, err_overrun;
  logic [1:0] tdiv = 0;
  int total = 0, fails = 0, n_done = 0;
  logic [7:0] cap_data;
  logic cap_pe, cap_fe, cap_ov, prev_done = 0;

  always #2 clk = ~clk;

  uart_rx_core u_uart_rx_core (.clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
    .baud_tick(baud_tick), .rx_in(rx_in), .par_mode(par_mode), .rd_strobe(rd_auto | rd_man),
    .rx_data(rx_data), .rx_done(rx_done), .full(full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun));

  always @(negedge clk) begin
    tdiv <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (prev_done && rx_done) chk("R5 done longer than one cycle", 1, 0);
    prev_done <= rx_done;
    if (rx_done) begin
      n_done++;
      cap_data = rx_data; cap_pe = err_parity; cap_fe = err_frame; cap_ov = err_overrun;
    end
    rd_auto <= auto_rd && rx_done;
  end

  task automatic bitt(input logic b);
    rx_in = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] m, input logic flip, input logic stopv);
    bitt(1'b0);
    for (int i = 0; i < 8; i++) bitt(d[i]);
    if (m == 2'b01) bitt((^d) ^ flip);
    if (m == 2'b10) bitt((~^d) ^ flip);
    bitt(stopv);
    rx_in = 1'b1;
  endtask

  task automatic idle(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_man = 1'b1;
    @(negedge clk) rd_man = 1'b0;
  endtask

  // {mode, data, flip parity, stop value, expected parity err, expected frame err}
  localparam logic [13:0] VEC [0:7] = '{
    {2'd0, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 8'hA3, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h37, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h37, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd0, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'hC4, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    #(4 * 190000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    chk("R11 rx_data", 32'(rx_data), 0);
    chk("R11 flags", 32'({full, err_parity, err_frame, err_overrun, rx_done}), 0);
    rst_n = 1;
    idle(20);

    // R1: one control alone does nothing
    pwr_en = 1; rx_en = 0; n0 = n_done;
    frame(8'h3C, 2'b00, 0, 1); idle(64);
    pwr_en = 0; rx_en = 1;
    frame(8'h3C, 2'b00, 0, 1); idle(64);
    chk("R1 no frame while one control low", 32'(n_done - n0), 0);
    pwr_en = 1; idle(64);

    for (int v = 0; v < 8; v++) begin
      par_mode = VEC[v][13:12];
      n0 = n_done;
      frame(VEC[v][11:4], VEC[v][13:12], VEC[v][3], VEC[v][2]);
      idle(64);
      chk("R5 one completion", 32'(n_done - n0), 1);
      chk("R4 data LSB first", 32'(cap_data), 32'(VEC[v][11:4]));
      chk("R7 parity flag", 32'(cap_pe), 32'(VEC[v][1]));
      chk("R8 frame flag", 32'(cap_fe), 32'(VEC[v][0]));
      chk("R10 cleared after read", 32'({full, err_parity, err_frame, err_overrun}), 0);
    end
    par_mode = 2'b00;

    // R3: short glitch rejected, then a clean frame
    n0 = n_done;
    rx_in = 0; repeat (16) @(negedge clk);
    idle(192);
    chk("R3 glitch gives no frame", 32'(n_done - n0), 0);
    frame(8'h5A, 2'b00, 0, 1); idle(64);
    chk("R3 frame after glitch", 32'(cap_data), 32'h5A);

    // R2: line low at enable must not start a frame
    rx_en = 0; rx_in = 0; idle(0); rx_in = 0;
    repeat (8) @(negedge clk);
    n0 = n_done;
    rx_en = 1;
    repeat (200) @(negedge clk);
    idle(64);
    frame(8'hE7, 2'b00, 0, 1); idle(700);
    chk("R2 single completion", 32'(n_done - n0), 1);
    chk("R2 data", 32'(cap_data), 32'hE7);

    // R9: back to back frames, single stop bit
    n0 = n_done;
    frame(8'h12, 2'b00, 0, 1);
    frame(8'h34, 2'b00, 0, 1);
    idle(64);
    chk("R9 two completions", 32'(n_done - n0), 2);
    chk("R9 second byte", 32'(cap_data), 32'h34);

    // R6: overrun keeps old byte and persists
    auto_rd = 0;
    frame(8'hA1, 2'b00, 0, 1); idle(64);
    chk("R6 first held", 32'({full, rx_data}), 32'h1A1);
    n0 = n_done;
    frame(8'hB2, 2'b00, 0, 1); idle(64);
    chk("R6 completion on overrun", 32'(n_done - n0), 1);
    chk("R6 overrun flag", 32'(err_overrun), 1);
    chk("R6 old byte kept", 32'(rx_data), 32'hA1);
    frame(8'hC3, 2'b00, 0, 1); idle(64);
    chk("R6 still overrun", 32'({err_overrun, rx_data}), 32'h1A1);
    do_read(); idle(4);
    chk("R10 read clears", 32'({full, err_parity, err_frame, err_overrun}), 0);
    frame(8'hD4, 2'b00, 0, 1); idle(64);
    chk("R6 new byte after read", 32'({err_overrun, rx_data}), 32'h0D4);
    do_read(); auto_rd = 1;

    // R1: drop power mid-frame
    n0 = n_done;
    bitt(0); bitt(1); bitt(0); bitt(1);
    pwr_en = 0;
    bitt(0); bitt(1); bitt(0); bitt(1); bitt(0); bitt(1); bitt(1);
    pwr_en = 1;
    idle(128);
    chk("R1 aborted frame silent", 32'(n_done - n0), 0);
    frame(8'h69, 2'b00, 0, 1); idle(64);
    chk("R1 works after re-enable", 32'(cap_data), 32'h69);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule